// File: doc/BRIEF.md
# Paged NIC Host Register File

This block is the byte-wide host register interface of a network controller. The host presents a 4-bit I/O offset with a write strobe and write data, and the read data follows the offset combinationally. Offset 0 always reaches the command register. Command bits [7:6] select a page, and that page banks every other offset, so one offset can reach different registers depending on the page.

The block holds the receive ring page pointers (start, stop, boundary, current). It also holds the transmit page and byte count, the remote-DMA start address and byte count, the data configuration byte, the six physical-address bytes, the eight multicast mask bytes, and the interrupt status and mask registers. Receive, transmit and DMA logic elsewhere raise status bits through one set-pulse vector. The block drives a level interrupt and a one-cycle transmit request, and exports the programmed pointers and counts to that logic.

Top module: `paged_nic_regs`

## Requirements
- R1: Offset 0 writes and reads the command register on every page. Command bits [7:6] give the page for all other offsets. The command resets to 0x00.
- R2: On page 0, writes land as follows: offset 1 ring start, 2 ring stop, 3 boundary, 4 transmit page, 5/6 transmit count low/high, 8/9 remote address low/high, 10/11 remote count low/high, 14 data configuration, 15 interrupt mask. Each value appears on its output port on the cycle after the write. Boundary also reads back at page 0 offset 3.
- R3: Page 1 offsets 1 to 15 are read/write bytes: physical address at offsets 1 to 6, current page at 7 (also on `curPage`), multicast mask at 8 to 15.
- R4: Interrupt status reads at page 0 offset 7. A host write there clears each status bit written as one and leaves the others unchanged. Bits: 0 rx ok, 1 tx ok, 2 rx error, 3 tx error, 4 overwrite, 5 counters, 6 remote DMA complete, 7 reset.
- R5: Each bit of `intSet` high for a cycle sets that status bit. A set wins over a host clear of the same bit in the same cycle.
- R6: `irq` is high exactly when status AND mask is non-zero. It follows any status or mask change on the next cycle.
- R7: A command write with bit 1 (start) and bit 3 or bit 4 (remote read/write) sets status bit 6 if the remote count is zero at that moment. With a non-zero count it does not.
- R8: A command write with bit 1 and bit 2 (transmit) pulses `txReq` for exactly one cycle, sets transmit status (page 0 offset 4) to 0x01, and sets status bit 1.
- R9: Reads return 0x00 for page 0 offsets other than 0, 3, 4 and 7, and for every offset except 0 on pages 2 and 3.
- R10: After reset the status register is 0x80, all other registers are 0x00, and `irq` is low.
- R11: Writes to offsets 1 to 15 on pages 2 and 3 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 4 | Host I/O offset |
| hostWrEn | input | 1 | Host write strobe |
| hostWrData | input | 8 | Host write data |
| hostRdData | output | 8 | Host read data for `hostAddr` |
| intSet | input | 8 | Status set pulses from receive, transmit and DMA logic |
| irq | output | 1 | Level interrupt |
| txReq | output | 1 | One-cycle transmit request |
| txPage | output | 8 | Transmit start page |
| txCount | output | 16 | Transmit byte count |
| ringStart | output | 8 | Receive ring first page |
| ringStop | output | 8 | Receive ring end page (exclusive) |
| ringBoundary | output | 8 | Receive ring boundary page |
| curPage | output | 8 | Receive current page |
| rdmaAddr | output | 16 | Remote DMA start address |
| rdmaCount | output | 16 | Remote DMA byte count |
| dataCfg | output | 8 | Data configuration byte |

## Verification
The hardest case to reach is a set pulse and a host write-one-to-clear that hit the same status bit in the same cycle, because the two sources are independent. The bench forces this case directly. It also drives sparse random `intSet` values during random status clears. The zero-count DMA case depends on the count programmed earlier, so the bench programs a zero count and then a non-zero count before each start, and random command bytes hit both cases.

// File: rtl/nicreg_pkg.sv
package nicreg_pkg;
  localparam int CMD_START = 1;
  localparam int CMD_TX    = 2;
  localparam int CMD_RRD   = 3;
  localparam int CMD_RWR   = 4;
  localparam int IS_TXOK   = 1;
  localparam int IS_DMADN  = 6;
  localparam int IS_RESET  = 7;
  localparam logic [7:0] TSR_SENT = 8'h01;

  typedef struct packed {
    logic        cmd;
    logic        ringStart;
    logic        ringStop;
    logic        bnd;
    logic        txPage;
    logic        txCntLo;
    logic        txCntHi;
    logic        rsaLo;
    logic        rsaHi;
    logic        rcLo;
    logic        rcHi;
    logic        dcfg;
    logic        imr;
    logic        isrClr;
    logic [15:0] page1;
    logic        kickTx;
    logic        kickDma;
  } strobe_t;
endpackage

// File: rtl/nicreg_ctrl.sv
module nicreg_ctrl
  import nicreg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        page,
  input  logic              rcntZero,
  output strobe_t           stb
);
  always_comb begin
    stb = '0;
    if (wrEn) begin
      if (addr == '0) begin
        stb.cmd     = 1'b1;
        stb.kickTx  = wrData[CMD_START] & wrData[CMD_TX];
        stb.kickDma = wrData[CMD_START] & (wrData[CMD_RRD] | wrData[CMD_RWR]) & rcntZero;
      end else begin
        unique case (page)
          2'd0: begin
            case (addr)
              4'd1:  stb.ringStart = 1'b1;
              4'd2:  stb.ringStop  = 1'b1;
              4'd3:  stb.bnd       = 1'b1;
              4'd4:  stb.txPage    = 1'b1;
              4'd5:  stb.txCntLo   = 1'b1;
              4'd6:  stb.txCntHi   = 1'b1;
              4'd7:  stb.isrClr    = 1'b1;
              4'd8:  stb.rsaLo     = 1'b1;
              4'd9:  stb.rsaHi     = 1'b1;
              4'd10: stb.rcLo      = 1'b1;
              4'd11: stb.rcHi      = 1'b1;
              4'd14: stb.dcfg      = 1'b1;
              4'd15: stb.imr       = 1'b1;
              default: ;
            endcase
          end
          2'd1: stb.page1[addr] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R11: upper pages produce no register strobe
  assert_upper_page_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr != '0 && page[1]) |-> (stb == '0));
  // R7: a DMA kick only comes from a command write
  assert_dma_kick_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.kickDma |-> (wrEn && addr == '0 && rcntZero));
endmodule

// File: rtl/nicreg_data.sv
module nicreg_data
  import nicreg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] intSet,
  output logic [DATA_W-1:0] rdData,
  output logic [1:0]        page,
  output logic              rcntZero,
  output logic              irq,
  output logic              txReq,
  output logic [DATA_W-1:0] txPage,
  output logic [2*DATA_W-1:0] txCount,
  output logic [DATA_W-1:0] ringStart,
  output logic [DATA_W-1:0] ringStop,
  output logic [DATA_W-1:0] ringBoundary,
  output logic [DATA_W-1:0] curPage,
  output logic [2*DATA_W-1:0] rdmaAddr,
  output logic [2*DATA_W-1:0] rdmaCount,
  output logic [DATA_W-1:0] dataCfg
);
  localparam int NUM_OFFS = 1 << ADDR_W;
  localparam int CNT_W    = 2 * DATA_W;

  logic [DATA_W-1:0] cmdQ, startQ, stopQ, bndQ, tpsrQ, dcfgQ, imrQ, isrQ, tsrQ;
  logic [CNT_W-1:0]  tcntQ, rsaQ, rcntQ;
  logic              txReqQ;
  logic [DATA_W-1:0] page1Q [NUM_OFFS];
  logic [DATA_W-1:0] clrMask, setMask;

  always_comb begin
    clrMask = stb.isrClr ? wrData : '0;
    setMask = intSet;
    setMask[IS_TXOK]  = setMask[IS_TXOK]  | stb.kickTx;
    setMask[IS_DMADN] = setMask[IS_DMADN] | stb.kickDma;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ <= '0; startQ <= '0; stopQ <= '0; bndQ <= '0; tpsrQ <= '0;
      dcfgQ <= '0; imrQ <= '0; tsrQ <= '0; tcntQ <= '0; rsaQ <= '0; rcntQ <= '0;
      isrQ <= DATA_W'(1) << IS_RESET;
      txReqQ <= 1'b0;
    end else begin
      if (stb.cmd)       cmdQ   <= wrData;
      if (stb.ringStart) startQ <= wrData;
      if (stb.ringStop)  stopQ  <= wrData;
      if (stb.bnd)       bndQ   <= wrData;
      if (stb.txPage)    tpsrQ  <= wrData;
      if (stb.dcfg)      dcfgQ  <= wrData;
      if (stb.imr)       imrQ   <= wrData;
      if (stb.txCntLo)   tcntQ[DATA_W-1:0]     <= wrData;
      if (stb.txCntHi)   tcntQ[CNT_W-1:DATA_W] <= wrData;
      if (stb.rsaLo)     rsaQ[DATA_W-1:0]      <= wrData;
      if (stb.rsaHi)     rsaQ[CNT_W-1:DATA_W]  <= wrData;
      if (stb.rcLo)      rcntQ[DATA_W-1:0]     <= wrData;
      if (stb.rcHi)      rcntQ[CNT_W-1:DATA_W] <= wrData;
      if (stb.kickTx)    tsrQ   <= TSR_SENT;
      txReqQ <= stb.kickTx;
      isrQ   <= (isrQ & ~clrMask) | setMask;
    end
  end

  assign page1Q[0] = '0;
  for (genvar i = 1; i < NUM_OFFS; i++) begin : g_page1
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              page1Q[i] <= '0;
      else if (stb.page1[i])  page1Q[i] <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == '0) rdData = cmdQ;
    else if (page == 2'd0) begin
      case (addr)
        4'd3: rdData = bndQ;
        4'd4: rdData = tsrQ;
        4'd7: rdData = isrQ;
        default: rdData = '0;
      endcase
    end else if (page == 2'd1) rdData = page1Q[addr];
  end

  assign page         = cmdQ[7:6];
  assign rcntZero     = (rcntQ == '0);
  assign irq          = |(isrQ & imrQ);
  assign txReq        = txReqQ;
  assign txPage       = tpsrQ;
  assign txCount      = tcntQ;
  assign ringStart    = startQ;
  assign ringStop     = stopQ;
  assign ringBoundary = bndQ;
  assign curPage      = page1Q[7];
  assign rdmaAddr     = rsaQ;
  assign rdmaCount    = rcntQ;
  assign dataCfg      = dcfgQ;

  // R5: every pulsed source bit is present next cycle
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (|intSet) |=> ((isrQ & $past(intSet)) == $past(intSet)));
  // R4: bits written as one are gone next cycle when no source sets them
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.isrClr && intSet == '0) |=> ((isrQ & $past(wrData)) == '0));
  // R8: transmit kick gives request, sent status and tx ok
  assert_tx_kick_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.kickTx |=> (txReq && tsrQ == TSR_SENT && isrQ[IS_TXOK]));
  // R7: zero-count DMA start completes at once
  assert_dma_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.kickDma |=> isrQ[IS_DMADN]);
  // R6: with status and mask unchanged the interrupt holds
  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(isrQ) && $stable(imrQ)) |-> $stable(irq));
  // R9: upper pages read as zero away from offset 0
  assert_upper_read_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (page[1] && addr != '0) |-> (rdData == '0));
endmodule

// File: rtl/paged_nic_regs.sv
module paged_nic_regs
  import nicreg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic [DATA_W-1:0] intSet,
  output logic              irq,
  output logic              txReq,
  output logic [DATA_W-1:0] txPage,
  output logic [2*DATA_W-1:0] txCount,
  output logic [DATA_W-1:0] ringStart,
  output logic [DATA_W-1:0] ringStop,
  output logic [DATA_W-1:0] ringBoundary,
  output logic [DATA_W-1:0] curPage,
  output logic [2*DATA_W-1:0] rdmaAddr,
  output logic [2*DATA_W-1:0] rdmaCount,
  output logic [DATA_W-1:0] dataCfg
);
  strobe_t    stb;
  logic [1:0] page;
  logic       rcntZero;

  nicreg_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(hostWrEn), .addr(hostAddr), .wrData(hostWrData),
    .page(page), .rcntZero(rcntZero), .stb(stb)
  );

  nicreg_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(hostAddr), .wrData(hostWrData),
    .intSet(intSet), .rdData(hostRdData), .page(page), .rcntZero(rcntZero),
    .irq(irq), .txReq(txReq), .txPage(txPage), .txCount(txCount),
    .ringStart(ringStart), .ringStop(ringStop), .ringBoundary(ringBoundary),
    .curPage(curPage), .rdmaAddr(rdmaAddr), .rdmaCount(rdmaCount), .dataCfg(dataCfg)
  );
endmodule

// File: tb/tb_paged_nic_regs.sv
module tb_paged_nic_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [7:0]  hostWrData = '0;
  logic [7:0]  hostRdData;
  logic [7:0]  intSet = '0;
  logic        irq, txReq;
  logic [7:0]  txPage, ringStart, ringStop, ringBoundary, curPage, dataCfg;
  logic [15:0] txCount, rdmaAddr, rdmaCount;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state
  logic [7:0] mCmd, mIsr, mTsr;
  logic [7:0] mP0 [16];
  logic [7:0] mP1 [16];
  bit         mTxFired;

  always #10 clk = ~clk;

  paged_nic_regs dut (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .intSet(intSet), .irq(irq),
    .txReq(txReq), .txPage(txPage), .txCount(txCount), .ringStart(ringStart),
    .ringStop(ringStop), .ringBoundary(ringBoundary), .curPage(curPage),
    .rdmaAddr(rdmaAddr), .rdmaCount(rdmaCount), .dataCfg(dataCfg)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [3:0] a);
    if (a == 0) return mCmd;
    case (mCmd[7:6])
      2'd0: case (a)
              4'd3: return mP0[3];
              4'd4: return mTsr;
              4'd7: return mIsr;
              default: return 8'h00;
            endcase
      2'd1: return mP1[a];
      default: return 8'h00;
    endcase
  endfunction

  function automatic string readTag(input logic [3:0] a);
    if (a == 0) return "R1";
    if (mCmd[7:6] == 2'd1) return "R3";
    if (mCmd[7:6] != 2'd0) return "R9";
    case (a)
      4'd3: return "R2";
      4'd4: return "R8";
      4'd7: return "R4";
      default: return "R9";
    endcase
  endfunction

  function automatic void modelReset();
    mCmd = 0; mIsr = 8'h80; mTsr = 0; mTxFired = 0;
    for (int i = 0; i < 16; i++) begin mP0[i] = 0; mP1[i] = 0; end
  endfunction

  // one clock: optional write plus set pulses, model update, output checks
  task automatic cyc(input bit we, input logic [3:0] a, input logic [7:0] d, input logic [7:0] s);
    logic [7:0] clr, setv;
    hostWrEn = we; hostAddr = a; hostWrData = d; intSet = s;
    @(negedge clk);
    hostWrEn = 0; intSet = 0;
    clr = 0; setv = s; mTxFired = 0;
    if (we) begin
      if (a == 0) begin
        if (d[1] && d[2]) begin mTxFired = 1; mTsr = 8'h01; setv[1] = 1; end
        if (d[1] && (d[3] || d[4]) && {mP0[11], mP0[10]} == 16'h0) setv[6] = 1;
        mCmd = d;
      end else if (mCmd[7:6] == 2'd0) begin
        if (a == 7) clr = d; else mP0[a] = d;
      end else if (mCmd[7:6] == 2'd1) mP1[a] = d;
    end
    mIsr = (mIsr & ~clr) | setv;
    chk("R8 txReq", txReq, mTxFired);
    chk("R6 irq", irq, |(mIsr & mP0[15]));
    chk("R2 ringStart", ringStart, mP0[1]);
    chk("R2 ringStop", ringStop, mP0[2]);
    chk("R2 boundary", ringBoundary, mP0[3]);
    chk("R2 txPage", txPage, mP0[4]);
    chk("R2 txCount", txCount, {mP0[6], mP0[5]});
    chk("R2 rdmaAddr", rdmaAddr, {mP0[9], mP0[8]});
    chk("R2 rdmaCount", rdmaCount, {mP0[11], mP0[10]});
    chk("R2 dataCfg", dataCfg, mP0[14]);
    chk("R3 curPage", curPage, mP1[7]);
    hostAddr = a; #1;
    chk(readTag(a), hostRdData, expRead(a));
  endtask

  task automatic sweep();
    for (int a = 0; a < 16; a++) begin
      hostAddr = 4'(a); #1;
      chk(readTag(4'(a)), hostRdData, expRead(4'(a)));
    end
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    if (!done) begin
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 irq", irq, 0);
    hostAddr = 7; #1; chk("R10 status", hostRdData, 8'h80);
    hostAddr = 0; #1; chk("R10 cmd", hostRdData, 8'h00);
    chk("R10 txReq", txReq, 0);
    sweep();

    // R2 page-0 programming
    cyc(1, 1, 8'h46, 0); cyc(1, 2, 8'h80, 0); cyc(1, 3, 8'h4c, 0);
    cyc(1, 4, 8'h40, 0); cyc(1, 5, 8'hea, 0); cyc(1, 6, 8'h05, 0);
    cyc(1, 8, 8'h34, 0); cyc(1, 9, 8'h12, 0); cyc(1, 14, 8'h49, 0);
    // R6 mask exposes the reset bit
    cyc(1, 15, 8'h80, 0);
    chk("R6 irq on mask", irq, 1);
    cyc(1, 7, 8'h80, 0);
    chk("R4 clear reset bit", irq, 0);
    // R8 transmit
    cyc(1, 15, 8'h3f, 0);
    cyc(1, 0, 8'h26, 0);
    chk("R8 txReq pulse", txReq, 1);
    cyc(0, 4, 0, 0);
    chk("R8 txReq one cycle", txReq, 0);
    chk("R8 tsr", hostRdData, 8'h01);
    // R7 zero count, then non-zero count
    cyc(1, 7, 8'hff, 0);
    cyc(1, 0, 8'h0a, 0);
    hostAddr = 7; #1; chk("R7 dma zero sets bit6", hostRdData[6], 1);
    cyc(1, 7, 8'h40, 0);
    cyc(1, 10, 8'h05, 0);
    cyc(1, 0, 8'h12, 0);
    hostAddr = 7; #1; chk("R7 nonzero count no bit6", hostRdData[6], 0);
    // R5 set collides with clear
    cyc(0, 0, 0, 8'h01);
    cyc(1, 7, 8'hff, 8'h01);
    hostAddr = 7; #1; chk("R5 set wins", hostRdData, 8'h01);
    // R3 page 1
    cyc(1, 0, 8'h62, 0);
    for (int a = 1; a < 16; a++) cyc(1, 4'(a), 8'(a * 17 + 3), 0);
    sweep();
    // R11 / R9 upper pages
    cyc(1, 0, 8'ha2, 0);
    for (int a = 1; a < 16; a++) cyc(1, 4'(a), 8'hff, 0);
    sweep();
    cyc(1, 0, 8'he2, 0);
    for (int a = 1; a < 16; a++) cyc(1, 4'(a), 8'h5a, 0);
    sweep();
    cyc(1, 0, 8'h22, 0);
    sweep();

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [3:0] a;
      logic [7:0] d, s;
      int r;
      r = $urandom_range(0, 99);
      a = 4'($urandom_range(0, 15));
      d = 8'($urandom);
      s = ($urandom_range(0, 3) == 0) ? 8'(1 << $urandom_range(0, 7)) : 8'h00;
      if (r < 12) cyc(1, 0, d, s);
      else if (r < 80) cyc(1, a, d, s);
      else cyc(0, a, d, s);
    end
    sweep();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule